// File: doc/BRIEF.md
# GPIO Port Block with Pin Interrupts

This block holds a bank of eight-pin general-purpose I/O ports behind a small register bus. Every port has an output latch and a direction mask. A direction bit of 1 turns the pin into a driver of its latch value. A direction bit of 0 leaves the pin as an input, and a read then returns the synchronized pad level. All pad inputs pass through a two-flop synchronizer before any logic uses them.

Ports 0, 1 and 5 also carry per-pin interrupt logic. Each pin can be set to edge or level detection and to either polarity, and it can use an optional debounce filter. An edge event is latched until a write-one-to-clear access removes it. The masked pending bits of ports 0 and 1 are merged onto one shared interrupt line. Port 5 drives one interrupt line per pin. The other ports are plain I/O.

Top module: `pinport_irq_ctrl`

## Requirements
- R1: After reset, all latches, direction masks, interrupt enables, trigger, polarity and debounce bits are 0. Therefore pad_oe is all zero, both interrupt outputs are low, and every pending read returns 0.
- R2: The word address is port*8 + sel, with these sel codes: 0 output latch, 1 direction, 2 interrupt enable, 3 trigger (1 = edge, 0 = level), 4 polarity (1 = rising/high, 0 = falling/low), 5 debounce enable, 6 clear (write-only, reads 0), 7 pending (read-only). Only wdata[7:0] is stored, and rdata[31:8] always reads 0. A read returns its data in the same cycle.
- R3: For each port p, pad_oe[p*8 +: 8] equals the direction mask and pad_out[p*8 +: 8] equals the latch. A read of sel 0 returns the latch bit for output pins and the synchronized pad bit for input pins.
- R4: On ports other than 0, 1 and 5, sel codes 2 to 7 read 0 and writes to them have no effect.
- R5: An edge-mode pin latches its status on the selected edge of its filtered input and holds it after the input returns to the other level.
- R6: Writing 1 to a bit of the clear register removes that pin's latched edge status. Bits written as 0 leave the status unchanged.
- R7: A level-mode pin's status follows its input while the selected level is present. A clear write has no effect on it.
- R8: Pending (sel 7) equals status AND interrupt enable. Masking a pin hides its status without discarding it.
- R9: irq_ab is high exactly when any pending bit of port 0 or port 1 is set.
- R10: irq_f[i] equals pending bit i of port 5.
- R11: With debounce enabled, a changed input is accepted only after it stays stable for DB_TICKS consecutive sample ticks, so shorter pulses are dropped. With debounce off, a pulse of a few cycles is still detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Word address: port index, then 3-bit register select |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data (low 8 bits used) |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| pad_in | input | 64 | Pad input levels, port p at bits p*8+7..p*8 |
| pad_out | output | 64 | Output latch values to the pads |
| pad_oe | output | 64 | Output enables to the pads |
| irq_ab | output | 1 | Shared interrupt of ports 0 and 1 |
| irq_f | output | 8 | Per-pin interrupts of port 5 |

## Verification
The bench builds the block with eight ports, DB_TICKS = 4 and TICK_DIV = 2. A sample tick therefore comes every second cycle, and the debounce window is about eight cycles. This keeps both sides of the filter within a few dozen cycles: a three-cycle pulse that must be dropped, a pulse still shorter than the window, and a long hold that must be accepted. Two tick-counter ends are covered. The bench exercises the divided tick path, and the tick-every-cycle variant is chosen only when TICK_DIV is 1.

// File: rtl/pinport_pkg.sv
package pinport_pkg;

    localparam int PIN_W = 8;
    localparam int SEL_W = 3;

    localparam int PORT_A = 0;
    localparam int PORT_B = 1;
    localparam int PORT_F = 5;

    typedef logic [PIN_W-1:0] pin_vec_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_DATA = 3'd0,
        SEL_DIR  = 3'd1,
        SEL_IEN  = 3'd2,
        SEL_TRIG = 3'd3,
        SEL_POL  = 3'd4,
        SEL_DEB  = 3'd5,
        SEL_CLR  = 3'd6,
        SEL_PEND = 3'd7
    } reg_sel_e;

    typedef struct packed {
        pin_vec_t ien;
        pin_vec_t trig;
        pin_vec_t pol;
        pin_vec_t deb;
    } pin_cfg_t;

    function automatic logic port_has_irq(input int p);
        return (p == PORT_A) || (p == PORT_B) || (p == PORT_F);
    endfunction

endpackage

// File: rtl/pinport_sync.sv
module pinport_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/pinport_debounce.sv
module pinport_debounce
    import pinport_pkg::*;
#(
    parameter int DB_TICKS = 4,
    localparam int CNT_W = $clog2(DB_TICKS + 1)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  pin_vec_t deb_en,
    input  pin_vec_t din,
    output pin_vec_t dout
);
    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
        logic [CNT_W-1:0] cnt_q;
        logic             filt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q  <= '0;
                filt_q <= 1'b0;
            end else if (!deb_en[i]) begin
                cnt_q  <= '0;
                filt_q <= din[i];
            end else if (din[i] == filt_q) begin
                cnt_q <= '0;
            end else if (tick) begin
                if (cnt_q == CNT_W'(DB_TICKS - 1)) begin
                    cnt_q  <= '0;
                    filt_q <= din[i];
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end

        assign dout[i] = filt_q;
    end
endmodule

// File: rtl/pinport_irq_unit.sv
module pinport_irq_unit
    import pinport_pkg::*;
#(
    parameter int DB_TICKS = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  pin_vec_t pin_s,
    input  logic     we,
    input  reg_sel_e sel,
    input  pin_vec_t wdata,
    output pin_vec_t rd_val,
    output pin_vec_t pend
);
    pin_cfg_t cfg_q;
    pin_vec_t filt;
    pin_vec_t prev_q;
    pin_vec_t stat_q;
    pin_vec_t clr_mask;
    pin_vec_t hit;
    pin_vec_t lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            case (sel)
                SEL_IEN:  cfg_q.ien  <= wdata;
                SEL_TRIG: cfg_q.trig <= wdata;
                SEL_POL:  cfg_q.pol  <= wdata;
                SEL_DEB:  cfg_q.deb  <= wdata;
                default:  ;
            endcase
        end
    end

    pinport_debounce #(.DB_TICKS(DB_TICKS)) u_deb (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .deb_en (cfg_q.deb),
        .din    (pin_s),
        .dout   (filt)
    );

    assign clr_mask = (we && sel == SEL_CLR) ? wdata : '0;
    assign hit = (cfg_q.pol & filt & ~prev_q) | (~cfg_q.pol & ~filt & prev_q);
    assign lvl = (cfg_q.pol & filt) | (~cfg_q.pol & ~filt);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            stat_q <= '0;
        end else begin
            prev_q <= filt;
            stat_q <= (cfg_q.trig & ((stat_q & ~clr_mask) | hit))
                    | (~cfg_q.trig & lvl);
        end
    end

    assign pend = stat_q & cfg_q.ien;

    always_comb begin
        case (sel)
            SEL_IEN:  rd_val = cfg_q.ien;
            SEL_TRIG: rd_val = cfg_q.trig;
            SEL_POL:  rd_val = cfg_q.pol;
            SEL_DEB:  rd_val = cfg_q.deb;
            SEL_PEND: rd_val = pend;
            default:  rd_val = '0;
        endcase
    end
endmodule

// File: rtl/pinport_irq_ctrl.sv
module pinport_irq_ctrl
    import pinport_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int DB_TICKS  = 4,
    parameter int TICK_DIV  = 16,
    localparam int PORT_W = $clog2(NUM_PORTS),
    localparam int ADDR_W = PORT_W + SEL_W,
    localparam int PADS   = NUM_PORTS * PIN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [PADS-1:0]   pad_in,
    output logic [PADS-1:0]   pad_out,
    output logic [PADS-1:0]   pad_oe,
    output logic              irq_ab,
    output logic [PIN_W-1:0]  irq_f
);
    logic [PORT_W-1:0] port_idx;
    reg_sel_e          sel;
    pin_vec_t          wbyte;
    logic [PADS-1:0]   pad_s;
    logic              tick;

    logic [NUM_PORTS-1:0][PIN_W-1:0] port_rd;
    logic [NUM_PORTS-1:0][PIN_W-1:0] pend_q;
    pin_vec_t pend_a;
    pin_vec_t pend_b;
    pin_vec_t pend_f;

    assign port_idx = bus_addr[ADDR_W-1:SEL_W];
    assign sel      = reg_sel_e'(bus_addr[SEL_W-1:0]);
    assign wbyte    = bus_wdata[PIN_W-1:0];

    if (TICK_DIV <= 1) begin : g_tick_every
        assign tick = 1'b1;
    end else begin : g_tick_div
        localparam int TW = $clog2(TICK_DIV);
        logic [TW-1:0] tcnt_q;
        always_ff @(posedge clk) begin
            if (rst)                                tcnt_q <= '0;
            else if (tcnt_q == TW'(TICK_DIV - 1))   tcnt_q <= '0;
            else                                    tcnt_q <= tcnt_q + 1'b1;
        end
        assign tick = (tcnt_q == TW'(TICK_DIV - 1));
    end

    pinport_sync #(.W(PADS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pad_s)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        pin_vec_t data_q;
        pin_vec_t dir_q;
        pin_vec_t irq_rd;
        pin_vec_t pin_s;
        logic     port_we;

        assign pin_s   = pad_s[p*PIN_W +: PIN_W];
        assign port_we = bus_we && (port_idx == PORT_W'(p));

        always_ff @(posedge clk) begin
            if (rst) begin
                data_q <= '0;
                dir_q  <= '0;
            end else if (port_we) begin
                if (sel == SEL_DATA) data_q <= wbyte;
                if (sel == SEL_DIR)  dir_q  <= wbyte;
            end
        end

        assign pad_out[p*PIN_W +: PIN_W] = data_q;
        assign pad_oe[p*PIN_W +: PIN_W]  = dir_q;

        if (port_has_irq(p)) begin : g_irq
            pinport_irq_unit #(.DB_TICKS(DB_TICKS)) u_irq (
                .clk    (clk),
                .rst    (rst),
                .tick   (tick),
                .pin_s  (pin_s),
                .we     (port_we),
                .sel    (sel),
                .wdata  (wbyte),
                .rd_val (irq_rd),
                .pend   (pend_q[p])
            );
        end else begin : g_plain
            assign irq_rd    = '0;
            assign pend_q[p] = '0;
        end

        assign port_rd[p] = (sel == SEL_DATA) ? ((dir_q & data_q) | (~dir_q & pin_s))
                          : (sel == SEL_DIR)  ? dir_q
                          : irq_rd;
    end

    always_comb begin
        bus_rdata = '0;
        if (int'(port_idx) < NUM_PORTS) bus_rdata[PIN_W-1:0] = port_rd[port_idx];
    end

    assign pend_a = pend_q[PORT_A];
    assign pend_b = pend_q[PORT_B];
    assign pend_f = pend_q[PORT_F];

    assign irq_ab = (|pend_a) | (|pend_b);
    assign irq_f  = pend_f;

endmodule

// File: rtl/pinport_irq_ctrl_chk.sv
module pinport_irq_ctrl_chk
    import pinport_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    localparam int PORT_W = $clog2(NUM_PORTS),
    localparam int ADDR_W = PORT_W + SEL_W,
    localparam int PADS   = NUM_PORTS * PIN_W
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [PADS-1:0]   pad_oe,
    input logic              irq_ab,
    input logic [PIN_W-1:0]  irq_f,
    input logic [PIN_W-1:0]  pend_a,
    input logic [PIN_W-1:0]  pend_b,
    input logic [PIN_W-1:0]  pend_f
);
    logic [PORT_W-1:0] c_port;
    logic [SEL_W-1:0]  c_sel;
    logic              plain_port;

    assign c_port     = bus_addr[ADDR_W-1:SEL_W];
    assign c_sel      = bus_addr[SEL_W-1:0];
    assign plain_port = !port_has_irq(int'(c_port));

    // R1: first cycle after reset shows quiet outputs
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && !irq_ab && irq_f == '0));

    // R2: upper read bits are zero
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[31:PIN_W] == '0);

    // R3: direction write on port 0 reaches the enables on the next cycle
    a_r3_dir_to_oe: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_we) && !$past(rst) && $past(bus_addr) == ADDR_W'(SEL_DIR))
        |-> pad_oe[PIN_W-1:0] == $past(bus_wdata[PIN_W-1:0]));

    // R4: plain ports expose no interrupt registers
    a_r4_plain_zero: assert property (@(posedge clk) disable iff (rst)
        (plain_port && c_sel >= SEL_W'(SEL_IEN)) |-> bus_rdata == '0);

    // R9: shared line follows ports 0 and 1
    a_r9_shared_line: assert property (@(posedge clk) disable iff (rst)
        irq_ab == ((|pend_a) || (|pend_b)));

    // R10: per-pin lines follow port 5
    a_r10_per_pin: assert property (@(posedge clk) disable iff (rst)
        irq_f == pend_f);

endmodule

bind pinport_irq_ctrl pinport_irq_ctrl_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .irq_ab    (irq_ab),
    .irq_f     (irq_f),
    .pend_a    (pend_a),
    .pend_b    (pend_b),
    .pend_f    (pend_f)
);

// File: tb/sim_pinport_irq_ctrl.sv
`timescale 1ns/1ps
module sim_pinport_irq_ctrl;
    localparam int NP   = 8;
    localparam int PADS = NP * 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [5:0]      bus_addr = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [PADS-1:0] pad_in = '0;
    logic [PADS-1:0] pad_out;
    logic [PADS-1:0] pad_oe;
    logic            irq_ab;
    logic [7:0]      irq_f;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pinport_irq_ctrl #(.NUM_PORTS(NP), .DB_TICKS(4), .TICK_DIV(2)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_ab(irq_ab), .irq_f(irq_f)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] ad(input int p, input int s);
        return 6'(p * 8 + s);
    endfunction

    task automatic wr(input int p, input int s, input logic [31:0] d);
        @(negedge clk);
        bus_addr = ad(p, s); bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input int p, input int s, output logic [31:0] d);
        @(negedge clk);
        bus_addr = ad(p, s); bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic pad(input int p, input int b, input logic v);
        @(negedge clk);
        pad_in[p*8 + b] = v;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 pad_oe", 32'(pad_oe != '0), 0);
        chk("R1 irq_ab", 32'(irq_ab), 0);
        chk("R1 irq_f", 32'(irq_f), 0);
        rd(0, 7, d); chk("R1 pending A", d, 0);
        rd(5, 2, d); chk("R1 enable F", d, 0);
        rd(1, 3, d); chk("R1 trigger B", d, 0);
    endtask

    task automatic t_regmap;
        logic [31:0] d;
        wr(3, 1, 32'hFFFF_FFA5);
        rd(3, 1, d); chk("R2 dir readback low byte only", d, 32'h0000_00A5);
        chk("R3 pad_oe port3", 32'(pad_oe[31:24]), 32'hA5);
        wr(3, 0, 32'h0000_003C);
        chk("R3 pad_out port3", 32'(pad_out[31:24]), 32'h3C);
        @(negedge clk); pad_in[31:24] = 8'hFF;
        wait_cyc(4);
        rd(3, 0, d); chk("R3 mixed data read", d, 32'h7E);
        rd(3, 6, d); chk("R2 clear reads zero", d, 0);
    endtask

    task automatic t_plain;
        logic [31:0] d;
        wr(3, 2, 32'hFF);
        rd(3, 2, d); chk("R4 plain enable ignored", d, 0);
        wr(4, 3, 32'hFF);
        rd(4, 3, d); chk("R4 plain trigger ignored", d, 0);
        rd(3, 7, d); chk("R4 plain pending zero", d, 0);
    endtask

    task automatic t_edge_a;
        logic [31:0] d;
        wr(0, 3, 32'h04); wr(0, 4, 32'h04);
        wait_cyc(2);
        wr(0, 6, 32'hFF); wr(0, 2, 32'h04);
        rd(0, 7, d); chk("R6 cleared before use", d, 0);
        pad(0, 2, 1'b1); wait_cyc(6);
        rd(0, 7, d); chk("R5 rising latched", d, 32'h04);
        chk("R9 shared line high", 32'(irq_ab), 1);
        pad(0, 2, 1'b0); wait_cyc(6);
        rd(0, 7, d); chk("R5 held after input drops", d, 32'h04);
        wr(0, 2, 32'h00);
        rd(0, 7, d); chk("R8 masked pending", d, 0);
        chk("R8 masked line", 32'(irq_ab), 0);
        wr(0, 2, 32'h04);
        rd(0, 7, d); chk("R8 status kept under mask", d, 32'h04);
        wr(0, 6, 32'h00);
        rd(0, 7, d); chk("R6 zero bits no effect", d, 32'h04);
        wr(0, 6, 32'h04);
        rd(0, 7, d); chk("R6 one bit clears", d, 0);
        chk("R9 shared line low", 32'(irq_ab), 0);
    endtask

    task automatic t_edge_b;
        logic [31:0] d;
        wr(1, 3, 32'h01); wr(1, 4, 32'h00);
        wait_cyc(2);
        wr(1, 6, 32'hFF); wr(1, 2, 32'h01);
        pad(1, 0, 1'b1); wait_cyc(6);
        rd(1, 7, d); chk("R5 falling mode ignores rise", d, 0);
        pad(1, 0, 1'b0); wait_cyc(6);
        rd(1, 7, d); chk("R5 falling latched", d, 32'h01);
        chk("R9 port B drives shared line", 32'(irq_ab), 1);
        wr(1, 6, 32'h01);
        chk("R9 shared line released", 32'(irq_ab), 0);
    endtask

    task automatic t_level_f;
        wr(5, 3, 32'h00); wr(5, 4, 32'h40); wr(5, 2, 32'h40);
        wait_cyc(2);
        chk("R7 level idle", 32'(irq_f), 0);
        pad(5, 6, 1'b1); wait_cyc(6);
        chk("R10 R7 level high asserts pin6", 32'(irq_f), 32'h40);
        wr(5, 6, 32'h40); wait_cyc(1);
        chk("R7 clear has no effect on level", 32'(irq_f), 32'h40);
        pad(5, 6, 1'b0); wait_cyc(6);
        chk("R7 level follows input", 32'(irq_f), 0);
    endtask

    task automatic t_debounce_f;
        wr(5, 2, 32'h00);
        wr(5, 3, 32'h03); wr(5, 4, 32'h03); wr(5, 5, 32'h02);
        wait_cyc(2);
        wr(5, 6, 32'hFF); wr(5, 2, 32'h03);
        pad(5, 0, 1'b1); wait_cyc(3); pad(5, 0, 1'b0);
        wait_cyc(8);
        chk("R11 short pulse seen without filter", 32'(irq_f), 32'h01);
        wr(5, 6, 32'h01);
        pad(5, 1, 1'b1); wait_cyc(3); pad(5, 1, 1'b0);
        wait_cyc(20);
        chk("R11 short pulse dropped by filter", 32'(irq_f), 0);
        pad(5, 1, 1'b1); wait_cyc(5);
        chk("R11 not accepted before window", 32'(irq_f), 0);
        wait_cyc(25);
        chk("R11 stable input accepted", 32'(irq_f), 32'h02);
        chk("R10 only pin1 line", 32'(irq_ab), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_plain();
        t_edge_a();
        t_edge_b();
        t_level_f();
        t_debounce_f();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule